// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits between a memory controller and a set of battery-backed static RAM banks. It conditions the active-low chip-enable so that no bank is written while the supply is unreliable. In normal operation a 2-bit bank select picks one of four active-low bank enables, and that enable copies the chip-enable request. All the other enables stay high.

A power-fail flag comes from an external comparator and arrives already synchronized. When it rises, no new access is started. An access whose request was already low at that moment may finish on the bank it started on. It is cut off if it outlasts a write-protect timeout. When the flag clears, every enable is held inactive for a long recovery hold-off so that the processor can settle. The same hold-off also follows reset.

The timeout and the hold-off are parameters counted in clock cycles. The default hold-off is 120 ms at a 125 MHz clock.

Top module: `pfce_gate`

## Requirements
- R1: While reset is low, and for exactly HOLD_CYC rising edges after it is released, `bank_en_n` is 4'b1111 and `wr_prot` is 1, whatever `req_n` does. On the next cycle the block is in normal operation.
- R2: In normal operation, bit i of `bank_en_n` equals `req_n` when `bank_sel` equals i, and every other bit is 1. This follows the inputs combinationally, so no more than one bit is ever low.
- R3: `wr_prot` is 0 in normal operation and 1 in every other state (draining, protected, recovering).
- R4: If `pwr_fail` rises while `req_n` is high, every enable stays high from that cycle on, for as long as `pwr_fail` stays high.
- R5: If `pwr_fail` is first seen high while `req_n` is low, that access continues on the bank that was selected in the detection cycle. Changes to `bank_sel` after detection have no effect on it.
- R6: During a continuing access, once `req_n` goes high all enables stay high. This holds even if `req_n` goes low again while `pwr_fail` is high.
- R7: A continuing access keeps its enable low for at most WPT_CYC cycles after the detection cycle. After that, all enables are forced high even though `req_n` is still low.
- R8: An access whose request goes low only after `pwr_fail` is already high never reaches any output.
- R9: When `pwr_fail` clears in the draining or protected state, all enables stay high for a full HOLD_CYC-cycle hold-off before normal operation resumes, and `req_n` is ignored meanwhile. If `pwr_fail` returns during the hold-off, the block is protected again, and the whole hold-off restarts when `pwr_fail` clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail | input | 1 | Power-fail flag, already synchronized, 1 = supply out of tolerance |
| req_n | input | 1 | Active-low chip-enable request |
| bank_sel | input | 2 | Index of the bank the request is meant for |
| bank_en_n | output | 4 | Conditioned active-low bank enables, bit i = bank i |
| wr_prot | output | 1 | 1 whenever the block is not in normal operation |

## Verification
The hardest situation to reach is a hold-off restart: the power-fail flag has to come back partway through a recovery count, and only the full length of the second hold-off shows whether the counter really started again from zero. The bench clears the flag, lets a few recovery cycles pass with the request held low, raises the flag for one cycle and then clears it again. It then counts every cycle up to the first normal cycle. The drain timeout is reached the same way, by keeping the request low past the detection cycle for longer than the write-protect window.

// File: rtl/pfce_pkg.sv
// Package: shared types for the power-fail chip-enable gate.
// Assumes: nothing beyond IEEE 1800-2017.
package pfce_pkg;

    // Controller state: normal pass-through, finishing an access,
    // fully blocked, or waiting out the recovery hold-off.
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_PROT   = 2'd2,
        ST_RECOV  = 2'd3
    } pf_state_e;

    // How the bank gate treats the request in the current cycle.
    typedef enum logic [1:0] {
        GATE_LIVE  = 2'd0,  // live bank select steers the request
        GATE_HELD  = 2'd1,  // bank latched at detection steers the request
        GATE_BLOCK = 2'd2   // every enable held inactive
    } gate_mode_e;

endpackage

// File: rtl/pfce_cycle_counter.sv
// Module: pfce_cycle_counter
// Counts clock cycles up to a limit supplied each cycle. The counter is
// shared between the drain timeout and the recovery hold-off.
// Assumes: clr takes priority over inc, and the count never passes the limit.
module pfce_cycle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] count_q;

    // Purpose: hold the elapsed cycle count; it clears on reset or on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc && !done) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Purpose: flag the last cycle of the current window.
    always_comb begin
        done = (count_q == limit);
    end

endmodule

// File: rtl/pfce_seq.sv
// Module: pfce_seq
// Sequencer for the power-fail gate. It tracks normal, drain, protected and
// recovery states and latches the bank that was active when power failed.
// Assumes: pwr_fail is already synchronous; WPT_CYC and HOLD_CYC are >= 1.
module pfce_seq
    import pfce_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int CNT_W    = 8,
    parameter int WPT_CYC  = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_fail,
    input  logic             req_n,
    input  logic [SEL_W-1:0] bank_sel,
    input  logic             cnt_done,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic [CNT_W-1:0] cnt_limit,
    output gate_mode_e       gate_mode,
    output logic [SEL_W-1:0] held_bank,
    output pf_state_e        state
);

    localparam logic [CNT_W-1:0] WPT_LIM  = CNT_W'(WPT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CYC - 1);

    pf_state_e        state_q;
    pf_state_e        state_d;
    logic [SEL_W-1:0] held_q;

    // Purpose: choose the next state from the flag, the request and the counter.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (pwr_fail) begin
                    state_d = req_n ? ST_PROT : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!pwr_fail) begin
                    state_d = ST_RECOV;
                end else if (req_n || cnt_done) begin
                    state_d = ST_PROT;
                end
            end
            ST_PROT: begin
                if (!pwr_fail) begin
                    state_d = ST_RECOV;
                end
            end
            ST_RECOV: begin
                if (pwr_fail) begin
                    state_d = ST_PROT;
                end else if (cnt_done) begin
                    state_d = ST_NORMAL;
                end
            end
            default: state_d = ST_PROT;
        endcase
    end

    // Purpose: restart the counter on every state change, advance it while timing.
    always_comb begin
        cnt_clr   = (state_d != state_q);
        cnt_inc   = (state_d == state_q) &&
                    ((state_q == ST_DRAIN) || (state_q == ST_RECOV));
        cnt_limit = (state_q == ST_DRAIN) ? WPT_LIM : HOLD_LIM;
    end

    // Purpose: register the state; reset lands in recovery so that power-up waits too.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RECOV;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: track the live bank in normal operation, so that it freezes at detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (state_q == ST_NORMAL) begin
            held_q <= bank_sel;
        end
    end

    // Purpose: tell the bank gate how to treat the request in this state.
    always_comb begin
        unique case (state_q)
            ST_NORMAL: gate_mode = GATE_LIVE;
            ST_DRAIN:  gate_mode = GATE_HELD;
            default:   gate_mode = GATE_BLOCK;
        endcase
    end

    assign held_bank = held_q;
    assign state     = state_q;

endmodule

// File: rtl/pfce_bank_gate.sv
// Module: pfce_bank_gate
// Decodes the steering bank index and passes the active-low request to
// exactly one enable, or blocks all of them.
// Assumes: NBANK is a power of two that matches SEL_W.
module pfce_bank_gate
    import pfce_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int SEL_W = 2
) (
    input  gate_mode_e       gate_mode,
    input  logic             req_n,
    input  logic [SEL_W-1:0] bank_sel,
    input  logic [SEL_W-1:0] held_bank,
    output logic [NBANK-1:0] bank_en_n
);

    logic [SEL_W-1:0] pick;
    logic             pass;

    // Purpose: pick the steering index and decide whether the request may pass.
    always_comb begin
        pick = (gate_mode == GATE_HELD) ? held_bank : bank_sel;
        pass = (gate_mode != GATE_BLOCK) && !req_n;
    end

    // One decoded enable per bank.
    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        assign bank_en_n[gi] = !(pass && (pick == SEL_W'(gi)));
    end

endmodule

// File: rtl/pfce_gate.sv
// Module: pfce_gate (top)
// Power-fail chip-enable gate. Conditions an active-low memory enable so
// that battery-backed banks are write protected while power is failing and
// during a recovery hold-off after power returns or after reset.
// Assumes: pwr_fail is synchronous to clk; the timeout and hold-off are in cycles.
module pfce_gate
    import pfce_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int CLK_KHZ  = 125000,
    parameter int HOLD_MS  = 120,
    parameter int WPT_CYC  = 64,
    parameter int HOLD_CYC = CLK_KHZ * HOLD_MS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_fail,
    input  logic                     req_n,
    input  logic [$clog2(NBANK)-1:0] bank_sel,
    output logic [NBANK-1:0]         bank_en_n,
    output logic                     wr_prot
);

    localparam int SEL_W = $clog2(NBANK);
    localparam int MAX_C = (WPT_CYC > HOLD_CYC) ? WPT_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic             cnt_clr;
    logic             cnt_inc;
    logic             cnt_done;
    logic [CNT_W-1:0] cnt_limit;
    gate_mode_e       gate_mode;
    logic [SEL_W-1:0] held_bank;
    pf_state_e        state;

    pfce_seq #(
        .SEL_W   (SEL_W),
        .CNT_W   (CNT_W),
        .WPT_CYC (WPT_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .req_n    (req_n),
        .bank_sel (bank_sel),
        .cnt_done (cnt_done),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .cnt_limit(cnt_limit),
        .gate_mode(gate_mode),
        .held_bank(held_bank),
        .state    (state)
    );

    pfce_cycle_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .limit(cnt_limit),
        .done (cnt_done)
    );

    pfce_bank_gate #(
        .NBANK(NBANK),
        .SEL_W(SEL_W)
    ) u_gate (
        .gate_mode(gate_mode),
        .req_n    (req_n),
        .bank_sel (bank_sel),
        .held_bank(held_bank),
        .bank_en_n(bank_en_n)
    );

    // Purpose: report protection in every state except normal.
    always_comb begin
        wr_prot = (state != ST_NORMAL);
    end

endmodule

// File: rtl/pfce_gate_chk.sv
// Module: pfce_gate_chk
// Port-level property checker for pfce_gate, attached with bind below.
// Assumes: it observes only the top-level ports.
module pfce_gate_chk #(
    parameter int NBANK    = 4,
    parameter int WPT_CYC  = 4,
    parameter int HOLD_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_fail,
    input logic             req_n,
    input logic [NBANK-1:0] bank_en_n,
    input logic             wr_prot
);

    localparam int HW = $clog2(HOLD_CYC + 3);
    localparam int WW = $clog2(WPT_CYC + 3);

    logic [HW-1:0] hold_q;
    logic [WW-1:0] live_q;

    // Purpose: count consecutive protected cycles with the power-fail flag clear.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_fail || !wr_prot) begin
            hold_q <= '0;
        end else if (hold_q != HW'(HOLD_CYC + 2)) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // Purpose: count consecutive cycles with the flag set and an enable low.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_fail || (&bank_en_n)) begin
            live_q <= '0;
        end else if (live_q != WW'(WPT_CYC + 2)) begin
            live_q <= live_q + 1'b1;
        end
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_en_n));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_n |-> (&bank_en_n));

    p_prot_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail) |-> wr_prot);

    p_stay_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && $past(pwr_fail) && $past(&bank_en_n)) |-> (&bank_en_n));

    p_new_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && $past(pwr_fail) && $past(req_n)) |-> (&bank_en_n));

    p_wpt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q <= WW'(WPT_CYC + 1));

    p_hold_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_prot && $past(wr_prot)) |-> (hold_q >= HW'(HOLD_CYC)));

endmodule

bind pfce_gate pfce_gate_chk #(
    .NBANK   (NBANK),
    .WPT_CYC (WPT_CYC),
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_fail (pwr_fail),
    .req_n    (req_n),
    .bank_en_n(bank_en_n),
    .wr_prot  (wr_prot)
);

// File: tb/test_pfce_gate.sv
// Bench for pfce_gate: a table walk, then directed reset and corner tests.
module test_pfce_gate;

    localparam int WPT  = 4;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_fail;
    logic       req_n;
    logic [1:0] bank_sel;
    logic [3:0] bank_en_n;
    logic       wr_prot;

    int n_chk = 0;
    int n_bad = 0;

    // {pwr_fail, req_n, bank_sel[1:0], exp bank_en_n[3:0], exp wr_prot}
    localparam logic [8:0] VEC [0:8] = '{
        {1'b0, 1'b1, 2'd0, 4'b1111, 1'b0},  // R2 idle
        {1'b0, 1'b0, 2'd0, 4'b1110, 1'b0},  // R2 bank 0
        {1'b0, 1'b0, 2'd2, 4'b1011, 1'b0},  // R2 bank 2
        {1'b0, 1'b0, 2'd3, 4'b0111, 1'b0},  // R2 bank 3
        {1'b0, 1'b0, 2'd1, 4'b1101, 1'b0},  // R2 bank 1
        {1'b0, 1'b1, 2'd1, 4'b1111, 1'b0},  // R2 release
        {1'b1, 1'b1, 2'd0, 4'b1111, 1'b0},  // R4 detection cycle, idle
        {1'b1, 1'b0, 2'd0, 4'b1111, 1'b1},  // R8 late request blocked
        {1'b0, 1'b0, 2'd0, 4'b1111, 1'b1}   // R9 flag clears, still protected
    };

    always #4 clk = ~clk;

    pfce_gate #(
        .NBANK   (4),
        .WPT_CYC (WPT),
        .HOLD_CYC(HOLD)
    ) i_pfce_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .req_n    (req_n),
        .bank_sel (bank_sel),
        .bank_en_n(bank_en_n),
        .wr_prot  (wr_prot)
    );

    task automatic cyc(input logic pf, input logic rq, input logic [1:0] sel);
        @(negedge clk);
        pwr_fail = pf;
        req_n    = rq;
        bank_sel = sel;
        #1;
    endtask

    task automatic check(input logic [3:0] e_en, input logic e_pr, input string tag);
        n_chk++;
        if (bank_en_n !== e_en || wr_prot !== e_pr) begin
            n_bad++;
            $display("FAIL %s: bank_en_n=%b wr_prot=%b expected bank_en_n=%b wr_prot=%b",
                     tag, bank_en_n, wr_prot, e_en, e_pr);
        end
    endtask

    task automatic to_normal();
        for (int i = 0; i < HOLD + 2; i++) cyc(1'b0, 1'b1, 2'd0);
        check(4'b1111, 1'b0, "R3 back to normal");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_fail = 1'b0; req_n = 1'b0; bank_sel = 2'd0;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 2'd0);
        check(4'b1111, 1'b1, "R1 in reset");

        // R1: release reset and time the power-up hold-off
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < HOLD - 1; i++) cyc(1'b0, 1'b0, 2'd0);
        check(4'b1111, 1'b1, "R1 hold-off last cycle");
        cyc(1'b0, 1'b0, 2'd0);
        check(4'b1110, 1'b0, "R1 first normal cycle");

        // Table walk
        for (int v = 0; v < 9; v++) begin
            cyc(VEC[v][8], VEC[v][7], VEC[v][6:5]);
            check(VEC[v][4:1], VEC[v][0], $sformatf("R2/R4/R8/R9 vector %0d", v));
        end
        to_normal();

        // R5/R6: access in progress continues on the latched bank, then locks
        cyc(1'b0, 1'b0, 2'd1); check(4'b1101, 1'b0, "R2 bank 1 before fail");
        cyc(1'b1, 1'b0, 2'd1); check(4'b1101, 1'b0, "R5 detection cycle");
        cyc(1'b1, 1'b0, 2'd3); check(4'b1101, 1'b1, "R5 latched bank");
        cyc(1'b1, 1'b1, 2'd3); check(4'b1111, 1'b1, "R6 request ends");
        cyc(1'b1, 1'b0, 2'd3); check(4'b1111, 1'b1, "R6 request again locked");
        to_normal();

        // R7: drain timeout
        cyc(1'b0, 1'b0, 2'd2); check(4'b1011, 1'b0, "R2 bank 2 before fail");
        cyc(1'b1, 1'b0, 2'd2); check(4'b1011, 1'b0, "R7 detection cycle");
        for (int k = 0; k < WPT; k++) begin
            cyc(1'b1, 1'b0, 2'd2);
            check(4'b1011, 1'b1, "R7 within window");
        end
        cyc(1'b1, 1'b0, 2'd2); check(4'b1111, 1'b1, "R7 forced inactive");
        to_normal();

        // R9: hold-off restart when power fails again during recovery
        cyc(1'b1, 1'b1, 2'd0); check(4'b1111, 1'b0, "R4 detection idle");
        cyc(1'b1, 1'b1, 2'd0); check(4'b1111, 1'b1, "R4 protected");
        cyc(1'b0, 1'b0, 2'd0); check(4'b1111, 1'b1, "R9 flag clears");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 2'd0);
            check(4'b1111, 1'b1, "R9 request ignored in recovery");
        end
        cyc(1'b1, 1'b0, 2'd0); check(4'b1111, 1'b1, "R9 fail during recovery");
        cyc(1'b0, 1'b0, 2'd0); check(4'b1111, 1'b1, "R9 protected again");
        for (int i = 0; i < HOLD; i++) begin
            cyc(1'b0, 1'b0, 2'd0);
            check(4'b1111, 1'b1, "R9 restarted hold-off");
        end
        cyc(1'b0, 1'b0, 2'd0); check(4'b1110, 1'b0, "R9 normal after full hold-off");

        // R9: flag clears while draining
        cyc(1'b1, 1'b0, 2'd0); check(4'b1110, 1'b0, "R5 detection cycle");
        cyc(1'b1, 1'b0, 2'd0); check(4'b1110, 1'b1, "R5 draining");
        cyc(1'b0, 1'b0, 2'd0); check(4'b1110, 1'b1, "R9 clear in drain");
        cyc(1'b0, 1'b0, 2'd0); check(4'b1111, 1'b1, "R9 drain to recovery");
        to_normal();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule